// File: doc/BRIEF.md
# Accumulator ALU with Condition Flags

A purely combinational arithmetic and logic unit for a small accumulator machine. It works on a byte accumulator, or on a double-width accumulator made of two bytes when `wide_i` is high. It takes two operands, the carry flag and a five-bit operation code. It returns the result, the new values of the half-carry (H), negative (N), zero (Z), overflow (V) and carry (C) flags, and a mask that names the flags this operation changes. It also returns a write-back strobe that is low for operations run only for their flags.

The caller holds the registers and the flag register. It writes `res_o` back when `wb_o` is high. It copies each flag whose bit in `upd_o` is set, and keeps the old value of the others. In 8-bit mode only the low byte of each operand is used, and the upper byte of the result is zero.

Top module: `acc_alu`

## Requirements
- R1: Add (op 0) and add-with-carry (op 1, which adds `c_i`) return the sum modulo 2^width. C is 1 when the true sum exceeds 2^width−1. The width is 8 bits, or 16 bits when `wide_i` is high.
- R2: Subtract (op 2), subtract-with-borrow (op 3, which also subtracts `c_i`) and compare (op 12) return the difference modulo 2^width. C is 1 when the true difference is below zero. Compare and bit test (op 18) hold `wb_o` at 0. Every other defined op holds it at 1.
- R3: For add, subtract, negate, increment and decrement, V is 1 exactly when the signed result falls outside the two's-complement range of the width.
- R4: H is the carry out of bit 3, and only 8-bit add and add-with-carry report it. The update mask `upd_o` has bits {H,N,Z,V,C} from bit 4 down to bit 0. Its H bit is set only for those two operations.
- R5: Z is 1 exactly when the result within the active width is zero. N is bit 7 of the result in 8-bit mode and bit 15 in 16-bit mode. Every defined op sets both N and Z in the mask.
- R6: AND (op 5), OR (op 6), XOR (op 7) and bit test (op 18, which gives the AND) force V to 0. They pass `c_i` to `c_o` and clear the C bit of the mask.
- R7: Clear (op 9) returns 0 with N=0, Z=1, V=0 and C=0. Complement (op 8) returns the ones' complement with V=0 and C=1.
- R8: Increment (op 10) and decrement (op 11) add or subtract one. They pass `c_i` to `c_o` and clear the C bit of the mask.
- R9: Shift left (op 13) fills the low bit with 0. Logical shift right (op 14) fills the top bit with 0. Arithmetic shift right (op 15) keeps the top bit. Every shift moves the bit shifted out into C.
- R10: Rotate left (op 16) and rotate right (op 17) rotate the operand and C together as one ring of width+1 bits. The old C enters at the vacated end, and the bit that leaves becomes the new C.
- R11: For every shift and rotate, V equals N XOR C of the result.
- R12: Negate (op 4) returns 0 minus the operand. C is 1 when the operand is nonzero. V is 1 only for the most negative value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 5 | Operation code |
| wide_i | input | 1 | 1 selects 16-bit width, 0 selects 8-bit |
| a_i | input | 16 | Accumulator operand |
| b_i | input | 16 | Second operand |
| c_i | input | 1 | Current carry flag |
| res_o | output | 16 | Result, upper byte zero in 8-bit mode |
| h_o | output | 1 | Half-carry flag |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| v_o | output | 1 | Overflow flag |
| c_o | output | 1 | Carry flag, equal to `c_i` when not updated |
| upd_o | output | 5 | Flags changed, {H,N,Z,V,C} |
| wb_o | output | 1 | Result is to be written back |

## Verification
The bound checker watches, on every input change, the rules that hold whatever the operand values are:
- logic ops clear V and keep C;
- clear gives its fixed flags;
- increment and decrement keep C;
- shifts and rotates give V = N XOR C;
- compare and bit test suppress write-back;
- the H mask bit appears only on byte additions.

The exact sums, borrows, signed-overflow points and half-carries can only be shown by the bench scenarios. These sweep every byte operand pair for add and subtract against an arithmetic model. Directed cases cover the edge values of negate, increment, decrement and the 16-bit shifts and rotates.

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic [4:0]        op_i,
  input  logic              wide_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  input  logic              c_i,
  output logic [WORD_W-1:0] res_o,
  output logic              h_o,
  output logic              n_o,
  output logic              z_o,
  output logic              v_o,
  output logic              c_o,
  output logic [4:0]        upd_o,
  output logic              wb_o
);
  localparam int HB = BYTE_W / 2;
  localparam logic [4:0] OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3;
  localparam logic [4:0] OP_NEG = 5'd4,  OP_AND = 5'd5,  OP_OR  = 5'd6,  OP_XOR = 5'd7;
  localparam logic [4:0] OP_COM = 5'd8,  OP_CLR = 5'd9,  OP_INC = 5'd10, OP_DEC = 5'd11;
  localparam logic [4:0] OP_CMP = 5'd12, OP_LSL = 5'd13, OP_LSR = 5'd14, OP_ASR = 5'd15;
  localparam logic [4:0] OP_ROL = 5'd16, OP_ROR = 5'd17, OP_BIT = 5'd18;
  localparam logic [WORD_W-1:0] LOW_MASK = {{BYTE_W{1'b0}}, {BYTE_W{1'b1}}};
  localparam logic [WORD_W-1:0] TOP_W = {1'b1, {(WORD_W-1){1'b0}}};
  localparam logic [WORD_W-1:0] TOP_B = {{BYTE_W{1'b0}}, 1'b1, {(BYTE_W-1){1'b0}}};

  logic [WORD_W-1:0] ax, by, msk, top, aw, sum, sh_l, sh_r;
  logic [BYTE_W:0]   sb;
  logic [WORD_W:0]   sw;
  logic              ci, cout, cin_msb, add_v, half, msb_in, shift_op, c_new, v_new;

  always_comb begin
    ax = a_i;
    by = b_i;
    ci = 1'b0;
    case (op_i)
      OP_ADC:         ci = c_i;
      OP_SUB, OP_CMP: begin by = ~b_i; ci = 1'b1; end
      OP_SBC:         begin by = ~b_i; ci = ~c_i; end
      OP_NEG:         begin ax = '0; by = ~a_i; ci = 1'b1; end
      OP_INC:         begin by = '0; ci = 1'b1; end
      OP_DEC:         by = '1;
      default:        ;
    endcase
  end

  assign sb = {1'b0, ax[BYTE_W-1:0]} + {1'b0, by[BYTE_W-1:0]} + {{BYTE_W{1'b0}}, ci};
  assign sw = {1'b0, ax} + {1'b0, by} + {{WORD_W{1'b0}}, ci};
  assign cout    = wide_i ? sw[WORD_W] : sb[BYTE_W];
  assign cin_msb = wide_i ? (ax[WORD_W-1] ^ by[WORD_W-1] ^ sw[WORD_W-1])
                          : (ax[BYTE_W-1] ^ by[BYTE_W-1] ^ sb[BYTE_W-1]);
  assign add_v = cout ^ cin_msb;
  assign half  = ax[HB] ^ by[HB] ^ sb[HB];
  assign sum   = wide_i ? sw[WORD_W-1:0] : {{BYTE_W{1'b0}}, sb[BYTE_W-1:0]};

  assign msk    = wide_i ? '1 : LOW_MASK;
  assign top    = wide_i ? TOP_W : TOP_B;
  assign aw     = a_i & msk;
  assign msb_in = wide_i ? a_i[WORD_W-1] : a_i[BYTE_W-1];
  assign sh_l   = {aw[WORD_W-2:0], 1'b0} & msk;
  assign sh_r   = {1'b0, aw[WORD_W-1:1]};

  always_comb begin
    res_o    = '0;
    c_new    = c_i;
    v_new    = 1'b0;
    h_o      = 1'b0;
    upd_o    = 5'b01111;
    wb_o     = 1'b1;
    shift_op = 1'b0;
    case (op_i)
      OP_ADD, OP_ADC: begin
        res_o = sum; c_new = cout; v_new = add_v;
        h_o   = half & ~wide_i;
        upd_o = wide_i ? 5'b01111 : 5'b11111;
      end
      OP_SUB, OP_SBC, OP_NEG, OP_CMP: begin
        res_o = sum; c_new = ~cout; v_new = add_v;
        wb_o  = (op_i != OP_CMP);
      end
      OP_INC, OP_DEC: begin
        res_o = sum; v_new = add_v; upd_o = 5'b01110;
      end
      OP_AND, OP_BIT: begin
        res_o = a_i & b_i & msk; upd_o = 5'b01110;
        wb_o  = (op_i != OP_BIT);
      end
      OP_OR:  begin res_o = (a_i | b_i) & msk; upd_o = 5'b01110; end
      OP_XOR: begin res_o = (a_i ^ b_i) & msk; upd_o = 5'b01110; end
      OP_COM: begin res_o = ~a_i & msk; c_new = 1'b1; end
      OP_CLR: c_new = 1'b0;
      OP_LSL: begin res_o = sh_l; c_new = msb_in; shift_op = 1'b1; end
      OP_ROL: begin res_o = sh_l | {{(WORD_W-1){1'b0}}, c_i}; c_new = msb_in; shift_op = 1'b1; end
      OP_LSR: begin res_o = sh_r; c_new = a_i[0]; shift_op = 1'b1; end
      OP_ASR: begin res_o = sh_r | (msb_in ? top : '0); c_new = a_i[0]; shift_op = 1'b1; end
      OP_ROR: begin res_o = sh_r | (c_i ? top : '0); c_new = a_i[0]; shift_op = 1'b1; end
      default: begin upd_o = 5'b00000; wb_o = 1'b0; end
    endcase
  end

  assign n_o = wide_i ? res_o[WORD_W-1] : res_o[BYTE_W-1];
  assign z_o = wide_i ? (res_o == '0) : (res_o[BYTE_W-1:0] == '0);
  assign c_o = c_new;
  assign v_o = shift_op ? (n_o ^ c_new) : v_new;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input logic [4:0]        op_i,
  input logic              wide_i,
  input logic              c_i,
  input logic [WORD_W-1:0] res_o,
  input logic              n_o,
  input logic              z_o,
  input logic              v_o,
  input logic              c_o,
  input logic [4:0]        upd_o,
  input logic              wb_o
);
  always_comb begin
    if (!$isunknown({op_i, wide_i, c_i})) begin
      // R6
      logic_v_clear_chk: assert (!(op_i inside {5'd5, 5'd6, 5'd7, 5'd18}) ||
                                 (!v_o && c_o == c_i && !upd_o[0]))
        else $error("logic op changed V or C");
      // R7
      clear_flags_chk: assert (op_i != 5'd9 ||
                               (res_o == '0 && z_o && !n_o && !v_o && !c_o))
        else $error("clear gave wrong flags");
      // R8
      incdec_carry_chk: assert (!(op_i inside {5'd10, 5'd11}) || (c_o == c_i && !upd_o[0]))
        else $error("inc/dec touched C");
      // R11
      shift_v_chk: assert (!(op_i inside {[5'd13:5'd17]}) || (v_o == (n_o ^ c_o)))
        else $error("shift V is not N^C");
      // R2
      flag_only_wb_chk: assert (!(op_i inside {5'd12, 5'd18}) || !wb_o)
        else $error("compare/test wrote back");
      // R4
      half_mask_chk: assert (!upd_o[4] || (!wide_i && op_i inside {5'd0, 5'd1}))
        else $error("H marked updated outside byte add");
    end
  end
endmodule

bind acc_alu acc_alu_chk #(.BYTE_W(BYTE_W)) u_acc_alu_chk (
  .op_i(op_i), .wide_i(wide_i), .c_i(c_i), .res_o(res_o), .n_o(n_o), .z_o(z_o),
  .v_o(v_o), .c_o(c_o), .upd_o(upd_o), .wb_o(wb_o)
);

// File: tb/acc_alu_bench.sv
module acc_alu_bench;
  typedef struct {
    logic [15:0] res;
    logic [4:0]  fl;
    logic [4:0]  m;
    logic        wb;
    string       tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] op_i = '0;
  logic wide_i = 1'b0;
  logic [15:0] a_i = '0, b_i = '0;
  logic c_i = 1'b0;
  logic [15:0] res_o;
  logic h_o, n_o, z_o, v_o, c_o, wb_o;
  logic [4:0] upd_o;

  int tests = 0, fails = 0, cycles = 0;
  item_t q[$];

  always #2.5 clk = ~clk;

  acc_alu u_acc_alu (.op_i(op_i), .wide_i(wide_i), .a_i(a_i), .b_i(b_i), .c_i(c_i),
    .res_o(res_o), .h_o(h_o), .n_o(n_o), .z_o(z_o), .v_o(v_o), .c_o(c_o),
    .upd_o(upd_o), .wb_o(wb_o));

  function automatic logic rng(longint s, longint half);
    return (s >= half) || (s < -half);
  endfunction

  function automatic item_t model(logic [4:0] op, logic wd, logic [15:0] a, logic [15:0] b,
                                  logic ci, string tag);
    item_t e;
    longint w = wd ? 16 : 8;
    longint mx = longint'(1) << w, hf = mx / 2;
    longint ua = longint'(a) & (mx - 1), ub = longint'(b) & (mx - 1);
    longint sa = (ua >= hf) ? ua - mx : ua, sb = (ub >= hf) ? ub - mx : ub;
    longint cv = ci ? 1 : 0, t = 0;
    logic h = 0, v = 0, c = ci, sh = 0, n;
    e.m = 5'b01111; e.wb = 1; e.tag = tag;
    case (op)
      0, 1: begin
        if (op == 0) cv = 0;
        t = ua + ub + cv; c = t >= mx; v = rng(sa + sb + cv, hf);
        h = !wd && ((ua & 15) + (ub & 15) + cv) > 15;
        e.m = wd ? 5'b01111 : 5'b11111;
      end
      2, 3, 12: begin
        if (op != 3) cv = 0;
        t = ua - ub - cv; c = t < 0; v = rng(sa - sb - cv, hf);
        e.wb = (op != 12);
      end
      4: begin t = -ua; c = ua != 0; v = rng(-sa, hf); end
      10, 11: begin
        t = (op == 10) ? ua + 1 : ua - 1;
        v = rng((op == 10) ? sa + 1 : sa - 1, hf); e.m = 5'b01110;
      end
      5, 18: begin t = ua & ub; e.m = 5'b01110; e.wb = (op != 18); end
      6: begin t = ua | ub; e.m = 5'b01110; end
      7: begin t = ua ^ ub; e.m = 5'b01110; end
      8: begin t = ~ua; c = 1; end
      9: begin t = 0; c = 0; end
      13: begin t = ua << 1; c = (ua >> (w - 1)) & 1; sh = 1; end
      16: begin t = (ua << 1) | cv; c = (ua >> (w - 1)) & 1; sh = 1; end
      14: begin t = ua >> 1; c = ua & 1; sh = 1; end
      15: begin t = (ua >> 1) | (ua & hf); c = ua & 1; sh = 1; end
      17: begin t = (ua >> 1) | (cv * hf); c = ua & 1; sh = 1; end
      default: begin e.m = 0; e.wb = 0; end
    endcase
    t = t & (mx - 1);
    e.res = 16'(t);
    n = ((t >> (w - 1)) & 1) != 0;
    if (sh) v = n ^ c;
    e.fl = {h, n, t == 0, v, c};
    return e;
  endfunction

  task automatic drive(logic [4:0] op, logic wd, logic [15:0] a, logic [15:0] b,
                       logic ci, string tag);
    @(posedge clk);
    #1;
    op_i = op; wide_i = wd; a_i = a; b_i = b; c_i = ci;
    q.push_back(model(op, wd, a, b, ci, tag));
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t e;
      logic [4:0] got, cm;
      e = q.pop_front();
      got = {h_o, n_o, z_o, v_o, c_o};
      cm = e.m | 5'b00001;
      tests++;
      if (res_o !== e.res || (got & cm) !== (e.fl & cm) || upd_o !== e.m || wb_o !== e.wb) begin
        fails++;
        $display("FAIL %s op=%0d a=%h b=%h c=%b: res=%h flags=%b mask=%b wb=%b expected res=%h flags=%b mask=%b wb=%b",
                 e.tag, op_i, a_i, b_i, c_i, res_o, got & cm, upd_o, wb_o,
                 e.res, e.fl & cm, e.m, e.wb);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R5: idle state with zero inputs gives zero result, Z set
    drive(0, 0, 16'h0000, 16'h0000, 0, "R5 reset");
    // R1 R3 R4 R5: full byte sweep of add/add-with-carry
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        drive((b % 2 == 0) ? 5'd0 : 5'd1, 0, 16'(a), 16'(b), a[0], "R1/R3/R4 add sweep");
    // R2 R3 R5: full byte sweep of subtract/subtract-with-borrow
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        drive((b % 2 == 0) ? 5'd2 : 5'd3, 0, 16'(a), 16'(b), a[1], "R2/R3 sub sweep");
    // R1 R3 16-bit add carry and overflow
    drive(0, 1, 16'hFFFF, 16'h0001, 0, "R1 wide carry");
    drive(0, 1, 16'h7FFF, 16'h0001, 0, "R3 wide overflow");
    drive(1, 1, 16'h00FF, 16'h0000, 1, "R1 wide adc");
    // R2 compare and borrow
    drive(12, 0, 16'h0010, 16'h0020, 0, "R2 compare borrow");
    drive(12, 1, 16'h8000, 16'h0001, 1, "R2 wide compare");
    drive(3, 1, 16'h0000, 16'h0000, 1, "R2 wide sbc borrow");
    // R12 negate
    drive(4, 0, 16'h0000, 16'h0, 0, "R12 neg zero");
    drive(4, 0, 16'h0080, 16'h0, 0, "R12 neg min");
    drive(4, 1, 16'h0001, 16'h0, 1, "R12 wide neg");
    // R6 logic ops keep C
    drive(5, 0, 16'h00F0, 16'h003C, 1, "R6 and");
    drive(6, 0, 16'h0080, 16'h0001, 0, "R6 or");
    drive(7, 1, 16'hFFFF, 16'hFFFF, 1, "R6 xor");
    drive(18, 0, 16'h0055, 16'h00AA, 1, "R6 bit test");
    // R7 clear and complement
    drive(9, 0, 16'h1234, 16'h0, 1, "R7 clear");
    drive(8, 0, 16'h00FF, 16'h0, 0, "R7 complement");
    drive(8, 1, 16'h0F0F, 16'h0, 0, "R7 wide complement");
    // R8 increment / decrement
    drive(10, 0, 16'h007F, 16'h0, 1, "R8 inc overflow");
    drive(10, 0, 16'h00FF, 16'h0, 0, "R8 inc wrap");
    drive(11, 0, 16'h0080, 16'h0, 1, "R8 dec overflow");
    drive(11, 1, 16'h0000, 16'h0, 0, "R8 wide dec wrap");
    // R9 R11 shifts
    drive(13, 0, 16'h00C1, 16'h0, 0, "R9 lsl");
    drive(14, 0, 16'h0081, 16'h0, 0, "R9 lsr");
    drive(15, 0, 16'h0081, 16'h0, 0, "R9 asr");
    drive(15, 1, 16'h8001, 16'h0, 0, "R9 wide asr");
    drive(13, 1, 16'h4000, 16'h0, 1, "R11 wide lsl");
    // R10 R11 rotates through carry
    drive(16, 0, 16'h0080, 16'h0, 1, "R10 rol");
    drive(17, 0, 16'h0001, 16'h0, 1, "R10 ror");
    drive(17, 1, 16'h0000, 16'h0, 1, "R10 wide ror");
    drive(16, 1, 16'h8000, 16'h0, 0, "R10 wide rol");
    @(posedge clk);
    wait (q.size() == 0);
    @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule